// File: doc/BRIEF.md
# TCP Send Segmentation Controller

This block runs one send-data command on an open TCP connection. The host programs a total byte count and a per-packet payload length, then pulses a start input. The block splits the transfer into packets of the programmed length plus, when the total is not an exact multiple, one short residue packet. It hands each packet to a downstream packet builder through a valid/ready request carrying the payload length. It never builds headers and never stores payload itself. It sees the transmit data buffer only through an occupancy count, and it frees acknowledged bytes with a release strobe.

Every acknowledgement number from the receive side is checked against the window of bytes in flight. Each accepted ACK moves the unacknowledged pointer forward and produces a release of the newly covered byte count. The residue packet is held back until every full-size packet has been acknowledged. By default it is then sent twice back to back, which draws a prompt ACK from the peer. The command finishes only when the last byte is acknowledged. A stop input aborts the command at any time.

Top module: `tcp_send_seg`

## Requirements
- R1: After reset, busy is 0, remain is 0, req_valid is 0, the residue mode bit is 0 and the stored packet length is 1460.
- R2: While the unsent count is at least the captured packet length, each request carries exactly that length. A total that is an exact multiple of the length produces exactly N requests and no duplicate.
- R3: When a residue exists, the N full packets are requested first. The residue request appears only after an accepted ACK has covered every byte of the full packets.
- R4: The residue mode bit sits at configuration address 2, bit 0. At 0 the residue is requested twice in a row, the second time with req_dup=1. At 1 it is requested once.
- R5: A first-time request is offered only while buf_level minus the bytes sent but not yet acknowledged is at least its length. A duplicate request needs no such check.
- R6: The total (address 0) and packet length (address 1) are captured when a start is accepted. Writes during a command affect only later commands, and a stored value persists until it is rewritten.
- R7: remain loads the total on an accepted start and drops by each first-time request's length on its handshake. Duplicates leave it unchanged.
- R8: busy falls only once an ACK covers the last byte of the transfer. It stays high for the first clock edge after the cycle that presents that ACK and is low after the second edge.
- R9: An ACK is accepted when the block is busy and ack_num minus the unacknowledged pointer, taken modulo 2^32, is nonzero and no larger than the bytes in flight. In that same cycle rel_valid=1 and rel_bytes equals that difference. Any other ACK produces no release.
- R10: A start while busy is ignored. A stop clears busy after the next clock edge, and remain then holds its value until a new start.
- R11: Writes of 0 or of more than 16000 to the packet-length address are ignored.
- R12: A request that is not accepted stays valid, with the same length and duplicate flag, until req_ready, unless stop aborts the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address: 0 total, 1 packet length, 2 residue mode |
| cfg_data | input | 32 | Configuration write data |
| start | input | 1 | Start a send command (ignored while busy) |
| stop | input | 1 | Abort the running command |
| start_seq | input | 32 | Sequence number of the first byte, sampled on start |
| buf_level | input | 16 | Bytes currently held in the transmit data buffer |
| ack_valid | input | 1 | Receive-side acknowledgement strobe |
| ack_num | input | 32 | Acknowledgement number |
| req_ready | input | 1 | Packet builder accepts the request |
| req_valid | output | 1 | Packet request offered |
| req_len | output | 16 | Payload length of the request |
| req_dup | output | 1 | Request repeats the residue packet |
| busy | output | 1 | Command in progress |
| remain | output | 32 | Bytes of the command not yet sent |
| rel_valid | output | 1 | Release strobe for acknowledged bytes |
| rel_bytes | output | 32 | Number of bytes released |

## Verification
The bench builds the block with its default parameters: 32-bit lengths, a 16-bit occupancy count, the duplicate variant compiled in, and the 1460 default and 16000 cap on packet length. Because the length fields are full width, a start sequence just below 2^32 puts the modulo window and release arithmetic across the wrap point. Short packet lengths of 4 and 10 bytes keep multi-packet, residue and buffer-starvation cases down to a few dozen cycles. The one 1460-byte check stays within the 16-bit occupancy count.

// File: rtl/tss_pkg.sv
package tss_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FULL,
      ST_WRES,
      ST_SRES,
      ST_SDUP,
      ST_DONE
   } tss_state_e;

   localparam logic [1:0] CFG_TOTAL = 2'd0;
   localparam logic [1:0] CFG_PKT   = 2'd1;
   localparam logic [1:0] CFG_MODE  = 2'd2;

endpackage

// File: rtl/tss_cfg.sv
module tss_cfg
   import tss_pkg::*;
#(
   parameter int LEN_W   = 32,
   parameter int PKT_W   = 16,
   parameter int PKT_DEF = 1460,
   parameter int PKT_MAX = 16000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [LEN_W-1:0] wr_data,
   output logic [LEN_W-1:0] tot_q,
   output logic [PKT_W-1:0] pkt_q,
   output logic             once_q
);

   localparam logic [LEN_W-1:0] PKT_MAX_L = LEN_W'(PKT_MAX);
   localparam logic [PKT_W-1:0] PKT_DEF_L = PKT_W'(PKT_DEF);

   logic pkt_legal;

   // length writes outside 1..PKT_MAX are dropped
   assign pkt_legal = (wr_data != '0) && (wr_data <= PKT_MAX_L);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tot_q  <= '0;
         pkt_q  <= PKT_DEF_L;
         once_q <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            CFG_TOTAL: tot_q  <= wr_data;
            CFG_PKT:   if (pkt_legal) pkt_q <= wr_data[PKT_W-1:0];
            CFG_MODE:  once_q <= wr_data[0];
            default:   ;
         endcase
      end
   end

endmodule

// File: rtl/tss_ack.sv
module tss_ack #(
   parameter int LEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_seq,
   input  logic             active,
   input  logic             ack_valid,
   input  logic [LEN_W-1:0] ack_num,
   input  logic [LEN_W-1:0] snd_nxt,
   output logic [LEN_W-1:0] una,
   output logic             rel_valid,
   output logic [LEN_W-1:0] rel_bytes
);

   logic [LEN_W-1:0] adv;
   logic [LEN_W-1:0] span;
   logic             accept;

   // modulo distances from the unacknowledged pointer
   assign adv    = ack_num - una;
   assign span   = snd_nxt - una;
   assign accept = active && ack_valid && (adv != '0) && (adv <= span);

   assign rel_valid = accept;
   assign rel_bytes = accept ? adv : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         una <= '0;
      end else if (load) begin
         una <= load_seq;
      end else if (accept) begin
         una <= ack_num;
      end
   end

endmodule

// File: rtl/tss_seg.sv
module tss_seg
   import tss_pkg::*;
#(
   parameter int LEN_W  = 32,
   parameter int PKT_W  = 16,
   parameter int CNT_W  = 16,
   parameter bit DUP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [LEN_W-1:0] tot_cfg,
   input  logic [PKT_W-1:0] pkt_cfg,
   input  logic             once_cfg,
   input  logic [LEN_W-1:0] start_seq,
   input  logic [CNT_W-1:0] buf_level,
   input  logic             req_ready,
   input  logic [LEN_W-1:0] una,
   output logic             req_valid,
   output logic [PKT_W-1:0] req_len,
   output logic             req_dup,
   output logic             busy,
   output logic [LEN_W-1:0] remain,
   output logic [LEN_W-1:0] snd_nxt,
   output logic             load
);

   localparam int PAD_P = LEN_W - PKT_W;
   localparam int PAD_C = LEN_W + 1 - CNT_W;

   tss_state_e       state;
   logic [PKT_W-1:0] pkt_cmd;
   logic [PKT_W-1:0] res_len;
   logic [LEN_W-1:0] end_seq;
   logic             once_cmd;
   logic             once_eff;

   logic [LEN_W-1:0] pkt_ext;
   logic [LEN_W-1:0] in_flight;
   logic [LEN_W:0]   need;
   logic [LEN_W:0]   have;
   logic             room;
   logic             want;
   logic             gated;
   logic             fire;
   logic             full_left;

   // residue repetition is a build-time option
   generate
      if (DUP_EN) begin : g_dup
         assign once_eff = once_cmd;
      end else begin : g_nodup
         assign once_eff = 1'b1;
      end
   endgenerate

   assign pkt_ext   = {{PAD_P{1'b0}}, pkt_cmd};
   assign full_left = (remain >= pkt_ext);
   assign in_flight = snd_nxt - una;

   always_comb begin
      req_len = pkt_cmd;
      req_dup = 1'b0;
      want    = 1'b0;
      gated   = 1'b1;
      case (state)
         ST_FULL: begin
            req_len = pkt_cmd;
            want    = full_left;
         end
         ST_SRES: begin
            req_len = remain[PKT_W-1:0];
            want    = 1'b1;
         end
         ST_SDUP: begin
            req_len = res_len;
            req_dup = 1'b1;
            want    = 1'b1;
            gated   = 1'b0;
         end
         default: ;
      endcase
   end

   // unsent buffered bytes must cover the packet
   assign need = {1'b0, in_flight} + {{(PAD_P + 1){1'b0}}, req_len};
   assign have = {{PAD_C{1'b0}}, buf_level};
   assign room = (have >= need);

   assign req_valid = want && (room || !gated);
   assign fire      = req_valid && req_ready;
   assign busy      = (state != ST_IDLE);
   assign load      = (state == ST_IDLE) && start && !stop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pkt_cmd  <= '0;
         res_len  <= '0;
         end_seq  <= '0;
         once_cmd <= 1'b0;
         remain   <= '0;
         snd_nxt  <= '0;
      end else if (stop) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  remain   <= tot_cfg;
                  pkt_cmd  <= pkt_cfg;
                  once_cmd <= once_cfg;
                  snd_nxt  <= start_seq;
                  end_seq  <= start_seq + tot_cfg;
                  state    <= ST_FULL;
               end
            end
            ST_FULL: begin
               if (fire) begin
                  remain  <= remain - pkt_ext;
                  snd_nxt <= snd_nxt + pkt_ext;
               end else if (!full_left) begin
                  state <= (remain == '0) ? ST_DONE : ST_WRES;
               end
            end
            ST_WRES: begin
               if (una == snd_nxt) state <= ST_SRES;
            end
            ST_SRES: begin
               if (fire) begin
                  res_len <= remain[PKT_W-1:0];
                  snd_nxt <= snd_nxt + remain;
                  remain  <= '0;
                  state   <= once_eff ? ST_DONE : ST_SDUP;
               end
            end
            ST_SDUP: begin
               if (fire) state <= ST_DONE;
            end
            ST_DONE: begin
               if (una == end_seq) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tcp_send_seg.sv
module tcp_send_seg #(
   parameter int LEN_W   = 32,
   parameter int PKT_W   = 16,
   parameter int CNT_W   = 16,
   parameter int PKT_DEF = 1460,
   parameter int PKT_MAX = 16000,
   parameter bit DUP_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_addr,
   input  logic [LEN_W-1:0] cfg_data,
   input  logic             start,
   input  logic             stop,
   input  logic [LEN_W-1:0] start_seq,
   input  logic [CNT_W-1:0] buf_level,
   input  logic             ack_valid,
   input  logic [LEN_W-1:0] ack_num,
   input  logic             req_ready,
   output logic             req_valid,
   output logic [PKT_W-1:0] req_len,
   output logic             req_dup,
   output logic             busy,
   output logic [LEN_W-1:0] remain,
   output logic             rel_valid,
   output logic [LEN_W-1:0] rel_bytes
);

   generate
      if (PKT_W >= LEN_W) begin : g_bad_pktw
         $error("packet length width must be narrower than total width");
      end
      if (CNT_W > LEN_W) begin : g_bad_cntw
         $error("occupancy width must not exceed total width");
      end
      if (PKT_MAX < 1 || PKT_MAX >= (2 ** PKT_W)) begin : g_bad_max
         $error("packet length cap does not fit its field");
      end
      if (PKT_DEF < 1 || PKT_DEF > PKT_MAX) begin : g_bad_def
         $error("default packet length outside legal range");
      end
   endgenerate

   logic [LEN_W-1:0] tot_q;
   logic [PKT_W-1:0] pkt_q;
   logic             once_q;
   logic [LEN_W-1:0] una;
   logic [LEN_W-1:0] snd_nxt;
   logic             load;

   tss_cfg #(
      .LEN_W  (LEN_W),
      .PKT_W  (PKT_W),
      .PKT_DEF(PKT_DEF),
      .PKT_MAX(PKT_MAX)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr),
      .wr_addr(cfg_addr),
      .wr_data(cfg_data),
      .tot_q  (tot_q),
      .pkt_q  (pkt_q),
      .once_q (once_q)
   );

   tss_seg #(
      .LEN_W (LEN_W),
      .PKT_W (PKT_W),
      .CNT_W (CNT_W),
      .DUP_EN(DUP_EN)
   ) u_seg (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .stop     (stop),
      .tot_cfg  (tot_q),
      .pkt_cfg  (pkt_q),
      .once_cfg (once_q),
      .start_seq(start_seq),
      .buf_level(buf_level),
      .req_ready(req_ready),
      .una      (una),
      .req_valid(req_valid),
      .req_len  (req_len),
      .req_dup  (req_dup),
      .busy     (busy),
      .remain   (remain),
      .snd_nxt  (snd_nxt),
      .load     (load)
   );

   tss_ack #(
      .LEN_W(LEN_W)
   ) u_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_seq (start_seq),
      .active   (busy && !stop),
      .ack_valid(ack_valid),
      .ack_num  (ack_num),
      .snd_nxt  (snd_nxt),
      .una      (una),
      .rel_valid(rel_valid),
      .rel_bytes(rel_bytes)
   );

endmodule

// File: rtl/tss_chk.sv
module tss_chk #(
   parameter int LEN_W   = 32,
   parameter int PKT_W   = 16,
   parameter int PKT_MAX = 16000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             stop,
   input logic             busy,
   input logic [LEN_W-1:0] remain,
   input logic             req_valid,
   input logic             req_ready,
   input logic [PKT_W-1:0] req_len,
   input logic             req_dup,
   input logic             rel_valid,
   input logic [LEN_W-1:0] rel_bytes
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid);

   assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len != '0) && (req_len <= PKT_W'(PKT_MAX)));

   assert_dup_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_dup) |-> (remain == '0));

   assert_done_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(stop)) |-> (remain == '0));

   assert_release_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> (rel_bytes != '0));

   assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !busy);

   assert_idle_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(remain));

   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !stop) |=>
         (req_valid && $stable(req_len) && $stable(req_dup)));

endmodule

bind tcp_send_seg tss_chk #(
   .LEN_W  (LEN_W),
   .PKT_W  (PKT_W),
   .PKT_MAX(PKT_MAX)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .stop     (stop),
   .busy     (busy),
   .remain   (remain),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .req_len  (req_len),
   .req_dup  (req_dup),
   .rel_valid(rel_valid),
   .rel_bytes(rel_bytes)
);

// File: tb/tcp_send_seg_test.sv
module tcp_send_seg_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_data = '0;
   logic        start = 1'b0;
   logic        stop = 1'b0;
   logic [31:0] start_seq = '0;
   logic [15:0] buf_level;
   logic        ack_valid = 1'b0;
   logic [31:0] ack_num = '0;
   logic        req_ready = 1'b1;
   logic        req_valid;
   logic [15:0] req_len;
   logic        req_dup;
   logic        busy;
   logic [31:0] remain;
   logic        rel_valid;
   logic [31:0] rel_bytes;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // packet sink record
   logic [15:0] plen [0:63];
   logic        pdup [0:63];
   int          pkt_n = 0;

   // transmit buffer model
   int lvl = 0;
   int add_amt = 0;
   logic flush = 1'b0;

   always #5 clk = ~clk;

   tcp_send_seg uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .start(start), .stop(stop), .start_seq(start_seq),
      .buf_level(buf_level), .ack_valid(ack_valid), .ack_num(ack_num),
      .req_ready(req_ready), .req_valid(req_valid), .req_len(req_len),
      .req_dup(req_dup), .busy(busy), .remain(remain),
      .rel_valid(rel_valid), .rel_bytes(rel_bytes)
   );

   assign buf_level = lvl[15:0];

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (req_valid && req_ready) begin
         plen[pkt_n[5:0]] <= req_len;
         pdup[pkt_n[5:0]] <= req_dup;
         pkt_n <= pkt_n + 1;
      end
      if (flush) lvl <= 0;
      else lvl <= lvl + add_amt - (rel_valid ? int'(rel_bytes) : 0);
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic pulse_start(input logic [31:0] seq);
      @(negedge clk);
      start = 1'b1; start_seq = seq;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
   endtask

   task automatic add_data(input int n);
      @(negedge clk);
      add_amt = n;
      @(negedge clk);
      add_amt = 0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic wait_pkts(input int target);
      for (int k = 0; k < 200 && pkt_n < target; k++) @(negedge clk);
   endtask

   task automatic send_ack(input logic [31:0] num, input logic ev, input logic [31:0] eb,
                           input string tag);
      @(negedge clk);
      ack_valid = 1'b1; ack_num = num;
      #1;
      check({tag, " rel_valid"}, {31'd0, rel_valid}, {31'd0, ev});
      if (ev) check({tag, " rel_bytes"}, rel_bytes, eb);
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 busy after reset", {31'd0, busy}, 32'd0);
      check("R1 remain after reset", remain, 32'd0);
      check("R1 req_valid after reset", {31'd0, req_valid}, 32'd0);
   endtask

   task automatic t_default();
      int base;
      base = pkt_n;
      add_data(2000);
      cfg_write(2'd0, 32'd1465);
      pulse_start(32'h1000);
      wait_pkts(base + 1);
      wait_cyc(3);
      check("R1 default length count", pkt_n - base, 32'd1);
      check("R1 default length", {16'd0, plen[base[5:0]]}, 32'd1460);
      check("R7 remain after one packet", remain, 32'd5);
      pulse_stop();
      check("R10 busy after stop", {31'd0, busy}, 32'd0);
      do_flush();
   endtask

   task automatic t_exact();
      int base;
      base = pkt_n;
      cfg_write(2'd1, 32'd10);
      cfg_write(2'd0, 32'd40);
      add_data(100);
      pulse_start(32'h100);
      wait_pkts(base + 4);
      wait_cyc(6);
      check("R2 exact count", pkt_n - base, 32'd4);
      for (int i = 0; i < 4; i++) begin
         check("R2 exact length", {16'd0, plen[(base + i) % 64]}, 32'd10);
         check("R2 exact no dup", {31'd0, pdup[(base + i) % 64]}, 32'd0);
      end
      check("R7 remain zero", remain, 32'd0);
      check("R8 busy before ack", {31'd0, busy}, 32'd1);
      send_ack(32'h100 + 32'd40, 1'b1, 32'd40, "R9 exact ack");
      check("R8 busy one edge after ack", {31'd0, busy}, 32'd1);
      @(negedge clk);
      check("R8 busy two edges after ack", {31'd0, busy}, 32'd0);
      do_flush();
   endtask

   task automatic t_residue_dup();
      int base;
      logic [31:0] s;
      s = 32'hFFFF_FFF0;
      base = pkt_n;
      cfg_write(2'd0, 32'd25);
      add_data(100);
      pulse_start(s);
      wait_pkts(base + 2);
      wait_cyc(6);
      check("R3 only full packets first", pkt_n - base, 32'd2);
      check("R7 remain is residue", remain, 32'd5);
      send_ack(s + 32'd10, 1'b1, 32'd10, "R9 partial ack wraps");
      wait_cyc(6);
      check("R3 residue held on partial ack", pkt_n - base, 32'd2);
      check("R8 busy held on partial ack", {31'd0, busy}, 32'd1);
      send_ack(s + 32'd20, 1'b1, 32'd10, "R9 second ack");
      wait_pkts(base + 4);
      wait_cyc(4);
      check("R4 residue sent twice", pkt_n - base, 32'd4);
      check("R4 residue length", {16'd0, plen[(base + 2) % 64]}, 32'd5);
      check("R4 residue first not dup", {31'd0, pdup[(base + 2) % 64]}, 32'd0);
      check("R4 repeat length", {16'd0, plen[(base + 3) % 64]}, 32'd5);
      check("R4 repeat flagged dup", {31'd0, pdup[(base + 3) % 64]}, 32'd1);
      check("R7 dup leaves remain", remain, 32'd0);
      send_ack(s + 32'd25, 1'b1, 32'd5, "R9 final ack");
      wait_cyc(1);
      check("R8 residue command done", {31'd0, busy}, 32'd0);
      do_flush();
   endtask

   task automatic t_residue_once();
      int base;
      base = pkt_n;
      cfg_write(2'd2, 32'd1);
      cfg_write(2'd0, 32'd7);
      add_data(50);
      pulse_start(32'h0);
      wait_pkts(base + 1);
      wait_cyc(6);
      check("R4 single residue count", pkt_n - base, 32'd1);
      check("R4 single residue length", {16'd0, plen[base % 64]}, 32'd7);
      send_ack(32'd7, 1'b1, 32'd7, "R9 once ack");
      wait_cyc(1);
      check("R8 once done", {31'd0, busy}, 32'd0);
      do_flush();
   endtask

   task automatic t_gate();
      int base;
      base = pkt_n;
      cfg_write(2'd0, 32'd20);
      pulse_start(32'h500);
      wait_cyc(6);
      check("R5 no data no request", pkt_n - base, 32'd0);
      add_data(9);
      wait_cyc(6);
      check("R5 short data no request", pkt_n - base, 32'd0);
      add_data(1);
      wait_cyc(4);
      check("R5 enough data one request", pkt_n - base, 32'd1);
      wait_cyc(4);
      check("R5 in-flight bytes not reusable", pkt_n - base, 32'd1);
      add_data(10);
      wait_cyc(4);
      check("R5 second request after refill", pkt_n - base, 32'd2);
      send_ack(32'h500 + 32'd20, 1'b1, 32'd20, "R9 gate ack");
      wait_cyc(1);
      check("R8 gate done", {31'd0, busy}, 32'd0);
      do_flush();
   endtask

   task automatic t_window();
      int base;
      base = pkt_n;
      cfg_write(2'd0, 32'd30);
      add_data(100);
      pulse_start(32'h800);
      wait_pkts(base + 3);
      wait_cyc(3);
      send_ack(32'h800, 1'b0, 32'd0, "R9 zero advance ignored");
      send_ack(32'h800 + 32'd31, 1'b0, 32'd0, "R9 beyond sent ignored");
      wait_cyc(2);
      check("R8 busy after ignored acks", {31'd0, busy}, 32'd1);
      send_ack(32'h800 + 32'd30, 1'b1, 32'd30, "R9 window ack");
      wait_cyc(1);
      check("R8 window done", {31'd0, busy}, 32'd0);
      do_flush();
   endtask

   task automatic t_capture();
      int base;
      base = pkt_n;
      cfg_write(2'd0, 32'd30);
      add_data(100);
      pulse_start(32'h900);
      cfg_write(2'd0, 32'd12);
      cfg_write(2'd1, 32'd4);
      wait_pkts(base + 3);
      wait_cyc(4);
      check("R6 captured total count", pkt_n - base, 32'd3);
      check("R6 captured length", {16'd0, plen[(base + 2) % 64]}, 32'd10);
      send_ack(32'h900 + 32'd30, 1'b1, 32'd30, "R6 capture ack");
      wait_cyc(2);
      do_flush();
      base = pkt_n;
      add_data(100);
      pulse_start(32'hA000);
      wait_cyc(2);
      check("R7 remain loads stored total", remain, 32'd4);
      wait_pkts(base + 3);
      wait_cyc(4);
      check("R6 stored values persist count", pkt_n - base, 32'd3);
      check("R6 stored length", {16'd0, plen[(base + 2) % 64]}, 32'd4);
      send_ack(32'hA000 + 32'd12, 1'b1, 32'd12, "R6 second ack");
      wait_cyc(2);
      do_flush();
   endtask

   task automatic t_pktlen();
      int base;
      base = pkt_n;
      cfg_write(2'd1, 32'd0);
      cfg_write(2'd1, 32'd16001);
      cfg_write(2'd0, 32'd8);
      add_data(100);
      pulse_start(32'h0);
      wait_pkts(base + 2);
      wait_cyc(4);
      check("R11 illegal lengths ignored count", pkt_n - base, 32'd2);
      check("R11 length kept", {16'd0, plen[base % 64]}, 32'd4);
      send_ack(32'd8, 1'b1, 32'd8, "R11 ack");
      wait_cyc(2);
      do_flush();
   endtask

   task automatic t_handshake();
      int base;
      base = pkt_n;
      req_ready = 1'b0;
      cfg_write(2'd0, 32'd4);
      add_data(10);
      pulse_start(32'h40);
      wait_cyc(3);
      check("R12 valid while stalled", {31'd0, req_valid}, 32'd1);
      check("R12 length while stalled", {16'd0, req_len}, 32'd4);
      wait_cyc(3);
      check("R12 still valid", {31'd0, req_valid}, 32'd1);
      check("R12 none accepted", pkt_n - base, 32'd0);
      @(negedge clk);
      req_ready = 1'b1;
      wait_pkts(base + 1);
      wait_cyc(2);
      check("R12 accepted once ready", pkt_n - base, 32'd1);
      send_ack(32'h44, 1'b1, 32'd4, "R12 ack");
      wait_cyc(2);
      do_flush();
   endtask

   task automatic t_busy_stop();
      cfg_write(2'd0, 32'd100);
      pulse_start(32'hB00);
      wait_cyc(3);
      check("R10 remain loaded", remain, 32'd100);
      cfg_write(2'd0, 32'd5);
      pulse_start(32'hC00);
      wait_cyc(3);
      check("R10 start while busy ignored", remain, 32'd100);
      check("R10 still busy", {31'd0, busy}, 32'd1);
      pulse_stop();
      check("R10 stop clears busy", {31'd0, busy}, 32'd0);
      wait_cyc(5);
      check("R10 remain frozen after stop", remain, 32'd100);
   endtask

   initial begin
      wait_cyc(4);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default();
      t_exact();
      t_residue_dup();
      t_residue_once();
      t_gate();
      t_window();
      t_capture();
      t_pktlen();
      t_handshake();
      t_busy_stop();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 50000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule